// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address belonging to one address-space context into a physical address. It does this by fetching directory entries and a final leaf entry from memory. The context is described by five values. Two 32-bit words give the window start. A 64-bit base word gives the root of the tree. A depth code sets how many directory levels there are. A size code sets how large the leaf table is. All five are captured at the moment a translation is started. The block then issues one 8-byte read at a time over a request/acknowledge port and takes each reply on a separate strobe. Replies may arrive after any number of cycles.

When the walk completes, a one-cycle completion pulse presents four results: the physical address, the flag that selects system memory rather than local memory, the valid flag, and the fragment code of the leaf. A directory entry with its valid bit clear stops the walk at once. At depth zero the base word is itself treated as the single directory entry. Only one translation is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: The window start is `(start_lo << 12) | (start_hi << 44)`, computed in 64 bits. This start is subtracted from the virtual address, and the 64-bit difference (the offset) is what every index is cut from.
- R2: A size code of 0 is treated as 4. For an effective size s, the leaf index of a walk with at least one directory level is `(offset >> (8+s))` masked to `9+s` bits. A size code of 4 therefore behaves the same as code 0.
- R3: At depth n ≥ 1 the root table address is `base << 12`. Directory levels are visited for d = n down to 1, with index `offset >> (9·d + 8 + s)`. The index at level n is used whole; the index at every later level is masked to its low 9 bits.
- R4: Each read address is `table + index·8`, truncated to the physical width, and is always 8-byte aligned. After a directory entry, the next table address is that entry ANDed with 0x0000_FFFF_FFFF_F000. The reads appear on the port in walk order.
- R5: At depth 0 the base word is decoded as a directory entry: valid in bit 0, fragment size in bits 63:59, table address equal to base ANDed with the same mask. The single leaf read uses index `offset >> (12 + fragment size)` with no masking.
- R6: From the leaf entry, the physical address is (entry AND 0x0000_FFFF_FFFF_F000) OR offset[11:0]. The system flag is bit 1, the valid flag is bit 0 and the fragment code is bits 11:7. These fields are reported even when the leaf's valid bit is 0.
- R7: A directory entry read with bit 0 clear ends the walk with no further reads. So does a depth-0 base word with bit 0 clear, in which case no read is made at all. The walk then completes with valid, system, fragment and address all 0.
- R8: Start is taken only while busy is low, and the context inputs are sampled on that cycle. Busy stays high until the completion pulse, which lasts one cycle with busy low. A start given while busy has no effect.
- R9: A read request and its address stay asserted and unchanged until acknowledged. The reply is taken on the data strobe after any delay. A request is only raised while busy.
- R10: After reset, busy, done and the request output are low, and the result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a translation (taken when idle) |
| vaddr | input | VA_W | Virtual address to translate |
| cfg_start_lo | input | 32 | Window start, low word (page units) |
| cfg_start_hi | input | 32 | Window start, high word (shifted by 44) |
| cfg_base | input | 64 | Root page number, or directory entry at depth 0 |
| cfg_depth | input | LVL_W | Number of directory levels |
| cfg_bsize | input | SIZE_W | Leaf table size code, 0 meaning 4 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| res_paddr | output | PA_W | Translated physical address |
| res_system | output | 1 | Target is system memory |
| res_valid | output | 1 | Translation valid |
| res_frag | output | 5 | Leaf fragment code |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | PA_W | Entry read address |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 64 | Read data (one entry) |

## Verification
The bench uses the default parameters: 48-bit virtual and physical addresses, a 2-bit depth code and a 4-bit size code. With these, walks of zero to three directory levels are all reachable. This means the unmasked topmost index, the masked lower indices and the base-as-entry path all occur. With 48-bit addresses, the 64-bit offset and the index shifts of up to 50 bits exercise truncation of the read address. Size codes of 0 and 4 through 8 show the default mapping and wider leaf tables. Randomized acknowledge and reply delays test the request-hold rule together with walk order.

// File: rtl/ptw_pkg.sv
// Shared types and entry field decoders for the page table walker.
// Assumes the 64-bit entry layout: directory fragment size in 63:59,
// table/page base in 47:12, leaf fragment in 11:7, system in 1, valid in 0.
package ptw_pkg;

    localparam logic [63:0] ENTRY_BASE_MASK = 64'h0000_FFFF_FFFF_F000;
    localparam int          FRAG_W          = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_state_t;

    function automatic logic entry_valid(input logic [63:0] raw);
        return raw[0];
    endfunction

    function automatic logic [63:0] entry_base(input logic [63:0] raw);
        return raw & ENTRY_BASE_MASK;
    endfunction

    function automatic logic [FRAG_W-1:0] dir_frag_size(input logic [63:0] raw);
        return raw[63:59];
    endfunction

    function automatic logic [FRAG_W-1:0] leaf_frag(input logic [63:0] raw);
        return raw[11:7];
    endfunction

    function automatic logic leaf_system(input logic [63:0] raw);
        return raw[1];
    endfunction

endpackage

// File: rtl/ptw_index_calc.sv
// Combinational entry address generator.
// For a directory level, it cuts the index from the offset at that level's
// shift and masks it to 9 bits unless this is the topmost level.
// For the leaf, it uses either a masked field of width 9+size or an unmasked
// shift (the depth-0 case).
// Assumes the level, size and shift inputs are held stable by the caller.
module ptw_index_calc #(
    parameter int PA_W   = 48,
    parameter int LVL_W  = 2,
    parameter int SIZE_W = 4
) (
    input  logic [63:0]       offset,
    input  logic [SIZE_W-1:0] eff_size,
    input  logic [LVL_W-1:0]  level,
    input  logic              first,
    input  logic [6:0]        leaf_shift,
    input  logic              leaf_masked,
    input  logic [PA_W-1:0]   table_base,
    output logic [PA_W-1:0]   entry_addr
);

    logic [6:0]  grain;
    logic [6:0]  dir_shift;
    logic [63:0] index;
    logic [63:0] sum;

    // page-granular base shift: 12 + (size - 4)
    assign grain     = 7'd8 + 7'(eff_size);
    assign dir_shift = 7'(level) * 7'd9 + grain;

    // select the index for the current step of the walk
    always_comb begin
        if (level != '0) begin
            index = offset >> dir_shift;
            if (!first) begin
                index = index & 64'h1FF;
            end
        end else if (leaf_masked) begin
            index = (offset >> grain) & ((64'd1 << (7'd9 + 7'(eff_size))) - 64'd1);
        end else begin
            index = offset >> leaf_shift;
        end
        sum = 64'(table_base) + (index << 3);
    end

    assign entry_addr = sum[PA_W-1:0];

endmodule

// File: rtl/ptw_result_hold.sv
// Result register and completion pulse.
// It loads the leaf fields on a leaf reply, or clears them on an aborted walk,
// and raises done for exactly one cycle. Assumes load_leaf and load_abort are
// never high together.
module ptw_result_hold #(
    parameter int PA_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_leaf,
    input  logic                    load_abort,
    input  logic [63:0]             leaf_raw,
    input  logic [11:0]             page_off,
    output logic [PA_W-1:0]         res_paddr,
    output logic                    res_system,
    output logic                    res_valid,
    output logic [ptw_pkg::FRAG_W-1:0] res_frag,
    output logic                    done
);
    import ptw_pkg::*;

    // hold the last translation result and pulse done on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_paddr  <= '0;
            res_system <= 1'b0;
            res_valid  <= 1'b0;
            res_frag   <= '0;
            done       <= 1'b0;
        end else begin
            done <= load_leaf | load_abort;
            if (load_leaf) begin
                res_paddr  <= PA_W'(entry_base(leaf_raw)) | PA_W'(page_off);
                res_system <= leaf_system(leaf_raw);
                res_valid  <= entry_valid(leaf_raw);
                res_frag   <= leaf_frag(leaf_raw);
            end else if (load_abort) begin
                res_paddr  <= '0;
                res_system <= 1'b0;
                res_valid  <= 1'b0;
                res_frag   <= '0;
            end
        end
    end

endmodule

// File: rtl/ptw_walker.sv
// Page table walker for one address-space context.
// It samples the context on start, subtracts the window start, then issues
// one 8-byte read per directory level plus one leaf read. Each request is
// held until acknowledged and each reply is taken on mem_rvalid.
// Assumes a reply never arrives in the same cycle as its acknowledge.
// SIZE_W must be at least 3 so that the default code 4 fits.
module ptw_walker #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 48,
    parameter int LVL_W  = 2,
    parameter int SIZE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [VA_W-1:0]      vaddr,
    input  logic [31:0]          cfg_start_lo,
    input  logic [31:0]          cfg_start_hi,
    input  logic [63:0]          cfg_base,
    input  logic [LVL_W-1:0]     cfg_depth,
    input  logic [SIZE_W-1:0]    cfg_bsize,
    output logic                 busy,
    output logic                 done,
    output logic [PA_W-1:0]      res_paddr,
    output logic                 res_system,
    output logic                 res_valid,
    output logic [4:0]           res_frag,
    output logic                 mem_req,
    output logic [PA_W-1:0]      mem_addr,
    input  logic                 mem_ack,
    input  logic                 mem_rvalid,
    input  logic [63:0]          mem_rdata
);
    import ptw_pkg::*;

    localparam logic [SIZE_W-1:0] DEFAULT_SIZE = SIZE_W'(4);

    walk_state_t       state;
    logic [63:0]       off_q;
    logic [SIZE_W-1:0] size_q;
    logic [LVL_W-1:0]  lvl_q;
    logic              first_q;
    logic [6:0]        leaf_shift_q;
    logic              leaf_masked_q;
    logic [PA_W-1:0]   base_q;

    logic [63:0]       win_start;
    logic [63:0]       off_next;
    logic [SIZE_W-1:0] size_next;
    logic              take_start;
    logic              reply;
    logic              load_leaf;
    logic              load_abort;

    // window start and offset from the sampled context
    assign win_start  = (64'(cfg_start_lo) << 12) | (64'(cfg_start_hi) << 44);
    assign off_next   = 64'(vaddr) - win_start;
    assign size_next  = (cfg_bsize == '0) ? DEFAULT_SIZE : cfg_bsize;
    assign take_start = (state == ST_IDLE) && start;
    assign reply      = (state == ST_WAIT) && mem_rvalid;

    // completion conditions: a leaf reply, or an invalid directory entry
    assign load_leaf  = reply && (lvl_q == '0);
    assign load_abort = (take_start && (cfg_depth == '0) && !entry_valid(cfg_base))
                      || (reply && (lvl_q != '0) && !entry_valid(mem_rdata));

    // walk sequencer: sample context, request, await reply, descend
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            off_q         <= '0;
            size_q        <= '0;
            lvl_q         <= '0;
            first_q       <= 1'b0;
            leaf_shift_q  <= '0;
            leaf_masked_q <= 1'b0;
            base_q        <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        off_q   <= off_next;
                        size_q  <= size_next;
                        first_q <= 1'b1;
                        lvl_q   <= cfg_depth;
                        if (cfg_depth != '0) begin
                            base_q        <= PA_W'(cfg_base << 12);
                            leaf_masked_q <= 1'b1;
                            leaf_shift_q  <= '0;
                            state         <= ST_REQ;
                        end else begin
                            base_q        <= PA_W'(entry_base(cfg_base));
                            leaf_masked_q <= 1'b0;
                            leaf_shift_q  <= 7'd12 + 7'(dir_frag_size(cfg_base));
                            state         <= entry_valid(cfg_base) ? ST_REQ : ST_IDLE;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_ack) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (lvl_q == '0) begin
                            state <= ST_IDLE;
                        end else if (entry_valid(mem_rdata)) begin
                            base_q  <= PA_W'(entry_base(mem_rdata));
                            lvl_q   <= lvl_q - 1'b1;
                            first_q <= 1'b0;
                            state   <= ST_REQ;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    ptw_index_calc #(
        .PA_W   (PA_W),
        .LVL_W  (LVL_W),
        .SIZE_W (SIZE_W)
    ) u_index (
        .offset      (off_q),
        .eff_size    (size_q),
        .level       (lvl_q),
        .first       (first_q),
        .leaf_shift  (leaf_shift_q),
        .leaf_masked (leaf_masked_q),
        .table_base  (base_q),
        .entry_addr  (mem_addr)
    );

    ptw_result_hold #(
        .PA_W (PA_W)
    ) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_leaf  (load_leaf),
        .load_abort (load_abort),
        .leaf_raw   (mem_rdata),
        .page_off   (off_q[11:0]),
        .res_paddr  (res_paddr),
        .res_system (res_system),
        .res_valid  (res_valid),
        .res_frag   (res_frag),
        .done       (done)
    );

    assign busy    = (state != ST_IDLE);
    assign mem_req = (state == ST_REQ);

endmodule

// File: rtl/ptw_walker_chk.sv
// Protocol checker for ptw_walker, attached by bind.
// It watches only the top-level ports.
module ptw_walker_chk #(
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_ack
);

    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_req));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_addr_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy || done));

endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/sim_ptw_walker.sv
// Bench for ptw_walker.
// Table memory is a hash of the read address. A reference walk computes the
// expected read sequence and result. Delays and stimulus come from a fixed seed.
module sim_ptw_walker;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] MASK = 64'h0000_FFFF_FFFF_F000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [47:0] vaddr;
    logic [31:0] cfg_start_lo, cfg_start_hi;
    logic [63:0] cfg_base;
    logic [1:0]  cfg_depth;
    logic [3:0]  cfg_bsize;
    logic        busy, done;
    logic [47:0] res_paddr;
    logic        res_system, res_valid;
    logic [4:0]  res_frag;
    logic        mem_req;
    logic [47:0] mem_addr;
    logic        mem_ack, mem_rvalid;
    logic [63:0] mem_rdata;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // memory behaviour knobs
    bit          rnd_inval = 0;
    bit          inval_en  = 0;
    logic [47:0] inval_addr = '0;

    // reference results
    logic [47:0] exp_addr [8];
    int          exp_n;
    logic [47:0] exp_pa;
    logic        exp_sys, exp_valid;
    logic [4:0]  exp_frag;
    logic [47:0] got_addr [8];
    int          got_n = 0;
    int          done_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
        .cfg_start_lo(cfg_start_lo), .cfg_start_hi(cfg_start_hi),
        .cfg_base(cfg_base), .cfg_depth(cfg_depth), .cfg_bsize(cfg_bsize),
        .busy(busy), .done(done), .res_paddr(res_paddr),
        .res_system(res_system), .res_valid(res_valid), .res_frag(res_frag),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [63:0] mem_word(input logic [47:0] a);
        logic [63:0] h;
        h = {16'h0, a} * 64'h9E37_79B9_7F4A_7C15;
        h = h ^ (h >> 29);
        h[0] = rnd_inval ? (h[3:2] != 2'b00) : 1'b1;
        if (inval_en && a == inval_addr) h[0] = 1'b0;
        return h;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference walk built from the requirements
    task automatic ref_walk(input logic [47:0] va, input logic [31:0] lo,
                            input logic [31:0] hi, input logic [63:0] base,
                            input logic [1:0] dep, input logic [3:0] bs);
        logic [63:0] off, tb, idx, sum, w;
        int sz;
        off = {16'h0, va} - (({32'h0, lo} << 12) | ({32'h0, hi} << 44));
        sz  = (bs == 0) ? 4 : int'(bs);
        exp_n = 0; exp_pa = '0; exp_sys = 0; exp_valid = 0; exp_frag = '0;
        if (dep == 0) begin
            if (!base[0]) return;
            tb  = base & MASK;
            idx = off >> (12 + int'(base[63:59]));
        end else begin
            tb = base << 12;
            for (int d = int'(dep); d >= 1; d--) begin
                idx = off >> (d * 9 + 8 + sz);
                if (d != int'(dep)) idx = idx & 64'h1FF;
                sum = tb + (idx << 3);
                exp_addr[exp_n] = sum[47:0];
                exp_n++;
                w = mem_word(sum[47:0]);
                if (!w[0]) return;
                tb = w & MASK;
            end
            idx = (off >> (8 + sz)) & ((64'd1 << (9 + sz)) - 64'd1);
        end
        sum = tb + (idx << 3);
        exp_addr[exp_n] = sum[47:0];
        exp_n++;
        w = mem_word(sum[47:0]);
        sum = (w & MASK) | {52'h0, off[11:0]};
        exp_pa = sum[47:0]; exp_sys = w[1]; exp_valid = w[0]; exp_frag = w[11:7];
    endtask

    // memory responder: random acknowledge and reply delays
    initial begin
        logic [47:0] ra;
        mem_ack = 0; mem_rvalid = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req === 1'b1) begin
                repeat ($urandom_range(0, 3)) @(negedge clk);
                ra = mem_addr;
                mem_ack = 1;
                @(negedge clk);
                mem_ack = 0;
                if (got_n < 8) got_addr[got_n] = ra;
                got_n++;
                repeat ($urandom_range(0, 4)) @(negedge clk);
                mem_rdata = mem_word(ra);
                mem_rvalid = 1;
                @(negedge clk);
                mem_rvalid = 0;
                mem_rdata = '0;
            end
        end
    end

    // completion pulse counter
    initial forever begin
        @(negedge clk);
        if (done === 1'b1) done_cnt++;
    end

    task automatic drive(input logic [47:0] va, input logic [31:0] lo,
                         input logic [31:0] hi, input logic [63:0] base,
                         input logic [1:0] dep, input logic [3:0] bs);
        vaddr = va; cfg_start_lo = lo; cfg_start_hi = hi;
        cfg_base = base; cfg_depth = dep; cfg_bsize = bs;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(input string req);
        int cyc = 0;
        while (done !== 1'b1 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 2000) check(req, "completion timeout", 64'd0, 64'd1);
    endtask

    task automatic compare(input string req);
        check(req, "paddr",  64'(res_paddr),  64'(exp_pa));
        check(req, "valid",  64'(res_valid),  64'(exp_valid));
        check(req, "system", 64'(res_system), 64'(exp_sys));
        check(req, "frag",   64'(res_frag),   64'(exp_frag));
        check(req, "read count", 64'(got_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < got_n && i < 8; i++)
            check("R4", "read address", 64'(got_addr[i]), 64'(exp_addr[i]));
    endtask

    task automatic run_one(input string req, input logic [47:0] va,
                           input logic [31:0] lo, input logic [31:0] hi,
                           input logic [63:0] base, input logic [1:0] dep,
                           input logic [3:0] bs);
        ref_walk(va, lo, hi, base, dep, bs);
        got_n = 0;
        drive(va, lo, hi, base, dep, bs);
        wait_done(req);
        compare(req);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; start = 0; vaddr = '0; cfg_start_lo = '0; cfg_start_hi = '0;
        cfg_base = '0; cfg_depth = '0; cfg_bsize = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "busy",    64'(busy),      64'd0);
        check("R10", "done",    64'(done),      64'd0);
        check("R10", "mem_req", 64'(mem_req),   64'd0);
        check("R10", "valid",   64'(res_valid), 64'd0);
        check("R10", "paddr",   64'(res_paddr), 64'd0);
        rst_n = 1;
        @(negedge clk);

        // R1 nonzero window start, low and high words
        run_one("R1", 48'h0000_1234_5678 + 48'h12000, 32'h12, 32'h0, 64'h0000_0000_0004_5001, 2'd1, 4'd0);
        run_one("R1", 48'h3000_0ABC_D123, 32'h0001_0000, 32'h3, 64'h0000_0000_0008_8000, 2'd1, 4'd0);

        // R2 default size code and wider leaf tables
        run_one("R2", 48'h0000_7F3A_B6C8, 32'h0, 32'h0, 64'h0000_0000_0000_0100, 2'd1, 4'd0);
        run_one("R2", 48'h0000_7F3A_B6C8, 32'h0, 32'h0, 64'h0000_0000_0000_0100, 2'd1, 4'd4);
        run_one("R2", 48'h0012_F3FA_B6C8, 32'h0, 32'h0, 64'h0000_0000_0000_0300, 2'd1, 4'd6);

        // R3 multi-level: top index unmasked, lower levels masked
        run_one("R3", 48'hFFFF_FFFF_F008, 32'h0, 32'h0, 64'h0000_0000_0001_0000, 2'd2, 4'd5);
        run_one("R3", 48'hABCD_EF01_2345, 32'h0, 32'h0, 64'h0000_0000_0002_0000, 2'd3, 4'd0);

        // R5 depth 0: base word acts as directory entry, fragment shift
        run_one("R5", 48'h0000_0123_4567, 32'h0, 32'h0, {5'd3, 11'h0, 48'h0000_0040_0001}, 2'd0, 4'd0);
        run_one("R5", 48'h00AB_CDEF_0123, 32'h0, 32'h0, {5'd0, 11'h0, 48'h0000_0800_0FFF}, 2'd0, 4'd7);

        // R7 invalid base word at depth 0: no reads
        run_one("R7", 48'h0000_0123_4567, 32'h0, 32'h0, 64'h0000_0000_0040_0000, 2'd0, 4'd0);

        // R7 invalid directory entry at the top level of a two-level walk
        ref_walk(48'h0055_6677_8899, 32'h0, 32'h0, 64'h0000_0000_0000_0777, 2'd2, 4'd0);
        inval_addr = exp_addr[0]; inval_en = 1;
        run_one("R7", 48'h0055_6677_8899, 32'h0, 32'h0, 64'h0000_0000_0000_0777, 2'd2, 4'd0);
        inval_en = 0;

        // R6 invalid leaf still reports its fields
        ref_walk(48'h0000_2345_6789, 32'h0, 32'h0, 64'h0000_0000_0000_0999, 2'd1, 4'd0);
        inval_addr = exp_addr[1]; inval_en = 1;
        run_one("R6", 48'h0000_2345_6789, 32'h0, 32'h0, 64'h0000_0000_0000_0999, 2'd1, 4'd0);
        inval_en = 0;

        // R8 start during a walk is ignored
        begin
            int dc;
            ref_walk(48'h0000_4444_5555, 32'h0, 32'h0, 64'h0000_0000_0000_0ABC, 2'd2, 4'd0);
            got_n = 0;
            drive(48'h0000_4444_5555, 32'h0, 32'h0, 64'h0000_0000_0000_0ABC, 2'd2, 4'd0);
            @(negedge clk);
            check("R8", "busy during walk", 64'(busy), 64'd1);
            drive(48'h0000_9999_0000, 32'h5, 32'h0, 64'h0000_0000_0000_0123, 2'd1, 4'd6);
            wait_done("R8");
            compare("R8");
            dc = done_cnt;
            repeat (30) @(negedge clk);
            check("R8", "no second completion", 64'(done_cnt), 64'(dc));
            check("R8", "idle after walk", 64'(busy), 64'd0);
        end

        // R9 random walks with random memory delays and random invalid entries
        rnd_inval = 1;
        for (int n = 0; n < 60; n++) begin
            logic [47:0] va;
            logic [63:0] bw;
            logic [3:0]  bs;
            logic [1:0]  dp;
            va = {$urandom(), $urandom()} ;
            bw = {$urandom(), $urandom()};
            dp = 2'($urandom_range(0, 3));
            bs = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(4, 8));
            run_one("R9", va, 32'($urandom_range(0, 255)), 32'($urandom_range(0, 1)), bw, dp, bs);
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=completed");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule